// File: doc/BRIEF.md
# Serial Port Test Clock Generator and Ring Router

This block feeds a bank of serial ports during loopback stress runs. Two free-running source clocks come in: a main source that times the transmit side of every port and an auxiliary source that times the receive side. The two may be asynchronous to each other. From each source the block divides down a port clock. The divide ratio is picked by a 3-bit static switch code. A separate switch moves the two lowest ports onto the fastest ratio. Every port also gets a transmit frame-sync strobe.

The block routes each port's transmit data onto the receive data pin of the next port up, and the last port wraps to port 0. A test pattern therefore walks the whole ring. Routed bits are re-timed by the receiving port's own clock. One switch holds every sync strobe low. Another switch floats every port-facing output.

The switch inputs are static and use open = 1 and closed = 0. Each switch passes through a two-flop synchronizer in each clock domain. That synchronizer presets to 1, so after reset the block acts as if every switch is open.

Top module: `portClockRouter`

## Requirements
- R1: The select code `swSel` sets the slow port clock period in source cycles: 0→2, 1→6, 2→8, 3→16, 4→32, 5→42.
- R2: Select codes 6 and 7 give a period of 2 source cycles.
- R3: Every divided clock spends equal numbers of source cycles high and low. When the code changes, the new ratio starts only at a period boundary, so no high or low phase has a length outside the legal half-periods {1,3,4,8,16,21}.
- R4: `rxClk` is divided from `clkAux` using the same code table. Its period is counted in `clkAux` cycles.
- R5: With `swFast`=1, ports 0 and 1 run their transmit and receive clocks at a period of 2 whatever the code. With `swFast`=0 they follow the code like every other port.
- R6: With `swSyncOff`=0, each port's `txSync` is high for exactly one period of that port's transmit clock, once every 256 such periods. It changes only when that clock rises.
- R7: With `swSyncOff`=1, every `txSync` output stays low.
- R8: `rxData[i]` takes `txData[i-1]`, and `rxData[0]` takes `txData[27]`. The value is captured at the rising edge of port i's receive clock.
- R9: With `swOutEn`=0, all of `txClk`, `txSync`, `rxClk` and `rxData` are high impedance. With `swOutEn`=1 they are driven.
- R10: After reset every switch reads as 1. The clocks run at a period of 2, ports 0 and 1 are on the fast ratio, sync is held low and the outputs are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMain | input | 1 | Main source clock, times the transmit side |
| clkAux | input | 1 | Auxiliary source clock, times the receive side |
| rstN | input | 1 | Asynchronous active-low reset |
| swSel | input | 3 | Divide ratio select code (open = 1) |
| swFast | input | 1 | 1: ports 0 and 1 use the fastest ratio |
| swSyncOff | input | 1 | 1: hold all sync strobes low |
| swOutEn | input | 1 | 1: drive port outputs, 0: high impedance |
| txData | input | NUM_PORTS | Transmit data from each port |
| txClk | output | NUM_PORTS | Transmit clock per port |
| txSync | output | NUM_PORTS | Transmit frame-sync strobe per port |
| rxClk | output | NUM_PORTS | Receive clock per port |
| rxData | output | NUM_PORTS | Ring-routed receive data per port |

## Verification
A switch change passes two synchronizer flops and can then wait up to one full old period before it takes effect. The bench therefore waits 150 source cycles after every switch write before it measures anything. Clock periods, duty and sync spacing are measured by counting samples taken on the falling edge of the clock's own source. Each count starts only after a complete rising edge has been seen. Routed data is checked after at least one full receive period has passed since `txData` last changed, and `rxData` is sampled on the falling edge of `clkAux`. Enable and sync-hold checks watch the outputs over a window of several hundred cycles rather than at a single instant.

// File: rtl/portclk_pkg.sv
package portclk_pkg;

  localparam int HALF_W = 5;

  // strobes from one clock domain's control to the datapath
  typedef struct packed {
    logic slowClk;
    logic slowRise;
    logic slowSync;
    logic fastClk;
    logic fastRise;
    logic fastSync;
    logic fastSel;
    logic syncOff;
    logic outEn;
  } portStrobe_t;

  // half period in source cycles for a select code
  function automatic logic [HALF_W-1:0] halfForCode(input logic [2:0] code);
    case (code)
      3'd0:    return HALF_W'(1);
      3'd1:    return HALF_W'(3);
      3'd2:    return HALF_W'(4);
      3'd3:    return HALF_W'(8);
      3'd4:    return HALF_W'(16);
      3'd5:    return HALF_W'(21);
      default: return HALF_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/swSync.sv
module swSync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // presets to all ones: an open switch reads as 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/clkDiv.sv
module clkDiv
  import portclk_pkg::*;
#(
  parameter int SYNC_PERIOD = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] halfReq,
  output logic              divClk,
  output logic              riseTick,
  output logic              syncPulse
);
  localparam int SYNC_W = (SYNC_PERIOD > 1) ? $clog2(SYNC_PERIOD) : 1;
  localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_PERIOD - 1);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] halfCur;
  logic [SYNC_W-1:0] syncCnt;
  logic              term;

  assign term     = (cnt == halfCur - 1'b1);
  assign riseTick = term & ~divClk;

  // the ratio is reloaded only when the high phase ends, so one period never mixes ratios
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      halfCur <= HALF_W'(1);
      divClk  <= 1'b0;
    end else if (term) begin
      cnt    <= '0;
      divClk <= ~divClk;
      if (divClk) halfCur <= halfReq;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // the sync pulse is one divided period wide, once per SYNC_PERIOD divided periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncCnt   <= '0;
      syncPulse <= 1'b0;
    end else if (riseTick) begin
      syncPulse <= (syncCnt == '0);
      syncCnt   <= (syncCnt == SYNC_LAST) ? '0 : syncCnt + 1'b1;
    end
  end
endmodule

// File: rtl/portTimer.sv
module portTimer
  import portclk_pkg::*;
#(
  parameter int SYNC_PERIOD = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  sel,
  input  logic        fastIn,
  input  logic        syncOffIn,
  input  logic        outEnIn,
  output portStrobe_t stb
);
  localparam int NUM_DIV = 2;   // index 0: selectable ratio, index 1: fastest ratio

  logic [5:0]        swQ;
  logic [2:0]        selQ;
  logic [HALF_W-1:0] halfReqV [NUM_DIV];
  logic [NUM_DIV-1:0] clkV, riseV, syncV;

  swSync #(.W(6)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({sel, fastIn, syncOffIn, outEnIn}),
    .q   (swQ)
  );

  assign selQ = swQ[5:3];

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam bit IS_FAST = (g == 1);
    assign halfReqV[g] = IS_FAST ? HALF_W'(1) : halfForCode(selQ);

    clkDiv #(.SYNC_PERIOD(SYNC_PERIOD)) u_div (
      .clk      (clk),
      .rstN     (rstN),
      .halfReq  (halfReqV[g]),
      .divClk   (clkV[g]),
      .riseTick (riseV[g]),
      .syncPulse(syncV[g])
    );
  end

  always_comb begin
    stb.slowClk  = clkV[0];
    stb.slowRise = riseV[0];
    stb.slowSync = syncV[0];
    stb.fastClk  = clkV[1];
    stb.fastRise = riseV[1];
    stb.fastSync = syncV[1];
    stb.fastSel  = swQ[2];
    stb.syncOff  = swQ[1];
    stb.outEn    = swQ[0];
  end
endmodule

// File: rtl/portRouter.sv
module portRouter
  import portclk_pkg::*;
#(
  parameter int NUM_PORTS  = 28,
  parameter int FAST_PORTS = 2
) (
  input  logic                 clkAux,
  input  logic                 rstN,
  input  portStrobe_t          txStb,
  input  portStrobe_t          rxStb,
  input  logic [NUM_PORTS-1:0] txData,
  output logic [NUM_PORTS-1:0] txClkRaw,
  output logic [NUM_PORTS-1:0] syncRaw,
  output logic [NUM_PORTS-1:0] rxClkRaw,
  output logic [NUM_PORTS-1:0] rxDataRaw
);
  // fields the top or the other direction consumes
  logic txUnused, rxUnused;
  assign txUnused = txStb.outEn ^ txStb.slowRise ^ txStb.fastRise;
  assign rxUnused = rxStb.slowSync ^ rxStb.fastSync ^ rxStb.syncOff ^ rxStb.outEn;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    localparam bit CAN_FAST = (i < FAST_PORTS);
    localparam int PREV     = (i + NUM_PORTS - 1) % NUM_PORTS;

    logic txFast, rxFast, rxRise;

    assign txFast = CAN_FAST && txStb.fastSel;
    assign rxFast = CAN_FAST && rxStb.fastSel;

    assign txClkRaw[i] = txFast ? txStb.fastClk : txStb.slowClk;
    assign syncRaw[i]  = (txFast ? txStb.fastSync : txStb.slowSync) & ~txStb.syncOff;
    assign rxClkRaw[i] = rxFast ? rxStb.fastClk : rxStb.slowClk;
    assign rxRise      = rxFast ? rxStb.fastRise : rxStb.slowRise;

    // ring hop: the previous port's transmit bit, captured as this port's receive clock rises
    always_ff @(posedge clkAux or negedge rstN) begin
      if (!rstN)       rxDataRaw[i] <= 1'b0;
      else if (rxRise) rxDataRaw[i] <= txData[PREV];
    end
  end
endmodule

// File: rtl/portClockRouter.sv
module portClockRouter
  import portclk_pkg::*;
#(
  parameter int NUM_PORTS   = 28,
  parameter int FAST_PORTS  = 2,
  parameter int SYNC_PERIOD = 256
) (
  input  logic                 clkMain,
  input  logic                 clkAux,
  input  logic                 rstN,
  input  logic [2:0]           swSel,
  input  logic                 swFast,
  input  logic                 swSyncOff,
  input  logic                 swOutEn,
  input  logic [NUM_PORTS-1:0] txData,
  output logic [NUM_PORTS-1:0] txClk,
  output logic [NUM_PORTS-1:0] txSync,
  output logic [NUM_PORTS-1:0] rxClk,
  output logic [NUM_PORTS-1:0] rxData
);
  portStrobe_t          txStb, rxStb;
  logic [NUM_PORTS-1:0] txClkRaw, syncRaw, rxClkRaw, rxDataRaw;

  portTimer #(.SYNC_PERIOD(SYNC_PERIOD)) u_txTimer (
    .clk(clkMain), .rstN(rstN), .sel(swSel), .fastIn(swFast),
    .syncOffIn(swSyncOff), .outEnIn(swOutEn), .stb(txStb)
  );

  portTimer #(.SYNC_PERIOD(SYNC_PERIOD)) u_rxTimer (
    .clk(clkAux), .rstN(rstN), .sel(swSel), .fastIn(swFast),
    .syncOffIn(swSyncOff), .outEnIn(swOutEn), .stb(rxStb)
  );

  portRouter #(.NUM_PORTS(NUM_PORTS), .FAST_PORTS(FAST_PORTS)) u_router (
    .clkAux   (clkAux),
    .rstN     (rstN),
    .txStb    (txStb),
    .rxStb    (rxStb),
    .txData   (txData),
    .txClkRaw (txClkRaw),
    .syncRaw  (syncRaw),
    .rxClkRaw (rxClkRaw),
    .rxDataRaw(rxDataRaw)
  );

  assign txClk  = txStb.outEn ? txClkRaw  : 'z;
  assign txSync = txStb.outEn ? syncRaw   : 'z;
  assign rxClk  = rxStb.outEn ? rxClkRaw  : 'z;
  assign rxData = rxStb.outEn ? rxDataRaw : 'z;
endmodule

// File: rtl/portClockRouterChk.sv
module portClockRouterChk
  import portclk_pkg::*;
#(
  parameter int NUM_PORTS  = 28,
  parameter int FAST_PORTS = 2
) (
  input logic                 clkMain,
  input logic                 clkAux,
  input logic                 rstN,
  input logic                 swSyncOff,
  input logic [NUM_PORTS-1:0] txData,
  input portStrobe_t          txStb,
  input portStrobe_t          rxStb,
  input logic [NUM_PORTS-1:0] syncRaw,
  input logic [NUM_PORTS-1:0] rxDataRaw
);
  logic       lastClk;
  logic [5:0] phase, lowLen;
  logic [1:0] rises;

  // measures the length of each phase of the slow transmit clock
  always_ff @(posedge clkMain or negedge rstN) begin
    if (!rstN) begin
      lastClk <= 1'b0;
      phase   <= '0;
      lowLen  <= '0;
      rises   <= '0;
    end else begin
      lastClk <= txStb.slowClk;
      if (txStb.slowClk != lastClk) begin
        phase <= 6'd1;
        if (txStb.slowClk) begin
          lowLen <= phase;
          if (rises != 2'd3) rises <= rises + 1'b1;
        end
      end else if (phase != 6'd63) begin
        phase <= phase + 1'b1;
      end
    end
  end

  a_r3_equal_halves: assert property (@(posedge clkMain) disable iff (!rstN)
    (rises >= 2'd2 && lastClk && !txStb.slowClk) |-> phase == lowLen)
    else $error("R3 high phase differs from the preceding low phase");

  a_r3_no_runt: assert property (@(posedge clkMain) disable iff (!rstN)
    (rises >= 2'd2 && txStb.slowClk != lastClk) |-> (phase inside {6'd1, 6'd3, 6'd4, 6'd8, 6'd16, 6'd21}))
    else $error("R3 illegal phase length");

  a_r6_sync_on_rise: assert property (@(posedge clkMain) disable iff (!rstN)
    !$stable(txStb.slowSync) |-> $rose(txStb.slowClk))
    else $error("R6 sync moved without a clock rise");

  a_r7_sync_held_low: assert property (@(posedge clkMain) disable iff (!rstN)
    (swSyncOff && $past(swSyncOff) && $past(swSyncOff, 2) && $past(swSyncOff, 3)) |-> syncRaw == '0)
    else $error("R7 sync active while forced low");

  a_r8_ring_hop: assert property (@(posedge clkAux) disable iff (!rstN)
    $rose(rxStb.slowClk) |-> rxDataRaw[FAST_PORTS] == $past(txData[FAST_PORTS-1]))
    else $error("R8 ring hop mismatch");

  a_r8_ring_wrap: assert property (@(posedge clkAux) disable iff (!rstN)
    (rxStb.fastSel && $past(rxStb.fastSel) && $rose(rxStb.fastClk)) |->
      rxDataRaw[0] == $past(txData[NUM_PORTS-1]))
    else $error("R8 ring wrap mismatch");
endmodule

bind portClockRouter portClockRouterChk #(.NUM_PORTS(NUM_PORTS), .FAST_PORTS(FAST_PORTS)) u_chk (
  .clkMain  (clkMain),
  .clkAux   (clkAux),
  .rstN     (rstN),
  .swSyncOff(swSyncOff),
  .txData   (txData),
  .txStb    (txStb),
  .rxStb    (rxStb),
  .syncRaw  (syncRaw),
  .rxDataRaw(rxDataRaw)
);

// File: tb/sim_portClockRouter.sv
module sim_portClockRouter;
  localparam int N = 28;

  logic         clkMain = 1'b0, clkAux = 1'b0, rstN = 1'b0;
  logic [2:0]   swSel = 3'b111;
  logic         swFast = 1'b1, swSyncOff = 1'b1, swOutEn = 1'b1;
  logic [N-1:0] txData = '0;
  wire  [N-1:0] txClk, txSync, rxClk, rxData;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clkMain = ~clkMain;   // 50 MHz
  always #13 clkAux  = ~clkAux;

  portClockRouter u0 (
    .clkMain(clkMain), .clkAux(clkAux), .rstN(rstN), .swSel(swSel),
    .swFast(swFast), .swSyncOff(swSyncOff), .swOutEn(swOutEn),
    .txData(txData), .txClk(txClk), .txSync(txSync), .rxClk(rxClk), .rxData(rxData)
  );

  function automatic int expPeriod(input logic [2:0] code);
    case (code)
      3'd0: return 2;   3'd1: return 6;  3'd2: return 8;
      3'd3: return 16;  3'd4: return 32; 3'd5: return 42;
      default: return 2;
    endcase
  endfunction

  function automatic logic [N-1:0] ringOf(input logic [N-1:0] t);
    return {t[N-2:0], t[N-1]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setSw(input logic [2:0] s, input logic f, input logic off, input logic oe);
    @(negedge clkMain);
    swSel = s; swFast = f; swSyncOff = off; swOutEn = oe;
    repeat (150) @(negedge clkMain);
  endtask

  // side 0: transmit clock in clkMain samples, side 1: receive clock in clkAux samples
  task automatic measClk(input int side, input int p, output int hi, output int lo);
    hi = 0; lo = 0;
    if (side == 0) begin
      @(negedge clkMain);
      while (txClk[p] !== 1'b0) @(negedge clkMain);
      while (txClk[p] !== 1'b1) @(negedge clkMain);
      while (txClk[p] === 1'b1) begin hi++; @(negedge clkMain); end
      while (txClk[p] === 1'b0) begin lo++; @(negedge clkMain); end
    end else begin
      @(negedge clkAux);
      while (rxClk[p] !== 1'b0) @(negedge clkAux);
      while (rxClk[p] !== 1'b1) @(negedge clkAux);
      while (rxClk[p] === 1'b1) begin hi++; @(negedge clkAux); end
      while (rxClk[p] === 1'b0) begin lo++; @(negedge clkAux); end
    end
  endtask

  task automatic measSync(input int p, output int w, output int gap);
    w = 0; gap = 0;
    @(negedge clkMain);
    while (txSync[p] === 1'b1) @(negedge clkMain);
    while (txSync[p] !== 1'b1) @(negedge clkMain);
    while (txSync[p] === 1'b1) begin w++; @(negedge clkMain); end
    gap = w;
    while (txSync[p] !== 1'b1) begin gap++; @(negedge clkMain); end
  endtask

  task automatic checkTx(input string req, input int p, input int expP);
    int hi, lo;
    measClk(0, p, hi, lo);
    check(hi + lo == expP, req, hi + lo, expP);
    check(hi == lo, {req, " duty R3"}, hi, lo);
  endtask

  task automatic checkRx(input string req, input int p, input int expP);
    int hi, lo;
    measClk(1, p, hi, lo);
    check(hi + lo == expP, req, hi + lo, expP);
  endtask

  task automatic checkRing(input logic [N-1:0] pat);
    @(negedge clkMain);
    txData = pat;
    repeat (60) @(negedge clkAux);
    check(rxData === ringOf(pat), "R8 ring routing", rxData, ringOf(pat));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clkMain);
    rstN = 1'b1;

    // R10 reset defaults: period 2, fast ports, sync held low, driven
    begin
      int seen = 0;
      for (int c = 0; c < 600; c++) begin
        @(negedge clkMain);
        if (|(txSync & ~(txSync ^ txSync))) seen++;
        for (int k = 0; k < N; k++) if (txSync[k] === 1'b1) seen++;
      end
      check(seen == 0, "R10 sync low after reset", seen, 0);
    end
    checkTx("R10 default period", 5, 2);
    checkTx("R10 default fast port", 0, 2);

    // R1, R2, R3, R4 directed sweep of every code
    for (int s = 0; s < 8; s++) begin
      setSw(3'(s), 1'b0, 1'b1, 1'b1);
      checkTx((s >= 6) ? "R2 fallback code" : "R1 tx ratio", 5, expPeriod(3'(s)));
      checkRx("R4 rx ratio", 9, expPeriod(3'(s)));
    end

    // R5 fast override
    setSw(3'd3, 1'b0, 1'b1, 1'b1);
    checkTx("R5 port0 follows code", 0, 16);
    setSw(3'd3, 1'b1, 1'b1, 1'b1);
    checkTx("R5 port0 fast", 0, 2);
    checkTx("R5 port1 fast", 1, 2);
    checkTx("R5 port2 unaffected", 2, 16);
    checkRx("R5 rx port1 fast", 1, 2);

    // R6 sync width and spacing
    setSw(3'd0, 1'b1, 1'b0, 1'b1);
    begin
      int w, gap;
      measSync(0, w, gap);
      check(w == 2, "R6 fast sync width", w, 2);
      check(gap == 512, "R6 fast sync spacing", gap, 512);
    end
    setSw(3'd1, 1'b1, 1'b0, 1'b1);
    begin
      int w, gap;
      measSync(7, w, gap);
      check(w == 6, "R6 slow sync width", w, 6);
      check(gap == 1536, "R6 slow sync spacing", gap, 1536);
    end

    // R7 sync forced low
    setSw(3'd0, 1'b1, 1'b1, 1'b1);
    begin
      int seen = 0;
      for (int c = 0; c < 1200; c++) begin
        @(negedge clkMain);
        for (int k = 0; k < N; k++) if (txSync[k] === 1'b1) seen++;
      end
      check(seen == 0, "R7 sync forced low", seen, 0);
    end

    // R8 ring routing: directed corners then random data
    setSw(3'd0, 1'b1, 1'b1, 1'b1);
    checkRing(28'h0000001);
    checkRing(28'h8000000);
    checkRing(28'h5555555);
    for (int it = 0; it < 5; it++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      setSw(s, 1'($urandom_range(0, 1)), 1'b1, 1'b1);
      checkRing(N'($urandom()));
    end

    // random ratio and override mix
    for (int it = 0; it < 6; it++) begin
      logic [2:0] s;
      logic f;
      s = 3'($urandom_range(0, 7));
      f = 1'($urandom_range(0, 1));
      setSw(s, f, 1'b1, 1'b1);
      checkTx("R1 random tx ratio", 3, expPeriod(s));
      checkTx("R5 random port0", 0, f ? 2 : expPeriod(s));
    end

    // R9 output enable
    @(negedge clkMain);
    txData = '1;
    setSw(3'd0, 1'b1, 1'b0, 1'b0);
    begin
      int seen = 0;
      for (int c = 0; c < 1200; c++) begin
        @(negedge clkMain);
        for (int k = 0; k < N; k++)
          if (txClk[k] === 1'b1 || txSync[k] === 1'b1 || rxClk[k] === 1'b1 || rxData[k] === 1'b1) seen++;
      end
      check(seen == 0, "R9 outputs floated", seen, 0);
    end
    setSw(3'd0, 1'b1, 1'b0, 1'b1);
    checkTx("R9 outputs driven again", 5, 2);
    check(rxData === '1, "R9 rx data driven again", rxData, {N{1'b1}});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clkMain);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule